// File: doc/BRIEF.md
# Decode Stage with Branch-Redirect Flush

This block sits between instruction fetch and rename in a processor front end. Fetch writes groups of up to `NWAY` instructions into a group queue, one group per cycle. Every slot carries an instruction address, the instruction bits and an operand field. When downstream accepts (valid/ready), the stage presents the group at the head of the queue. Before it does so, the stage scans the group for unconditional branches.

For each such branch the stage computes the target and compares it with the address that fetch placed after the branch. That address is the next slot in the group or, for the last valid slot, slot 0 of the next queued group. If the two agree, the group passes through whole. At the first disagreement the group is cut after the branch, and only the slots up to and including the branch go downstream. In the following cycle a single-cycle flush goes to the branch predictor, fetch, the micro-op unit and the mux, together with the redirect target. The queue is emptied in that same cycle.

The control has two states. `ST_RUN` is the normal state, where groups are accepted and presented. `ST_FLUSH` lasts exactly one cycle, drives the flush and clears the queue. The transitions are RUN→FLUSH, taken when a cut group is accepted downstream, and FLUSH→RUN, taken unconditionally. The head of the queue is classified as `HD_EMPTY` (no group), `HD_DEFER` (the last valid slot is a branch and no next group is queued yet) or `HD_READY`. A group is presented only in `HD_READY`.

Top module: `decode_redirect_stage`

## Requirements
- R1: After reset, `out_valid`, `flush_o` and `q_full` are 0 and `redirect_o` is zero.
- R2: Groups whose branches all agree with their successor addresses leave the stage in the order they were written. Their slot-valid mask, addresses, instruction bits and operands are unchanged. Input slot-valid masks are contiguous from slot 0.
- R3: `q_full` is 1 exactly when `QDEPTH` groups are held. A write offered while `q_full` is 1 is dropped.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the presented group stays unchanged.
- R5: A slot is an unconditional branch when instruction bits [INSN_W-1:INSN_W-6] equal 6'b111000. Its target is its address plus bits [19:0] (two's complement) multiplied by 4.
- R6: When a branch's target equals its successor address, or the group has no branch, all valid slots of the group are presented and no flush follows.
- R7: When a branch at slot k has a target that differs from its successor address, `out_slot_vld` shows only slots 0..k. In the cycle after that group is accepted, `flush_o` is 1 for exactly one cycle and `redirect_o` carries the target. `redirect_o` is zero whenever `flush_o` is 0.
- R8: Only the first disagreeing branch in a group acts. Branches after it do not change the cut or the redirect.
- R9: A branch in the last valid slot is compared with slot 0 of the next queued group. While no next group is queued, `out_valid` stays 0.
- R10: In the flush cycle the queue is emptied and a write offered in that cycle is dropped, so `out_valid` is 0 afterwards until a new group is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch offers a group this cycle |
| in_slot_vld | input | NWAY | Per-slot valid of the offered group |
| in_addr | input | NWAY*ADDR_W | Per-slot instruction address |
| in_insn | input | NWAY*INSN_W | Per-slot instruction bits |
| in_opnd | input | NWAY*OPND_W | Per-slot operand field |
| q_full | output | 1 | Queue holds QDEPTH groups |
| out_valid | output | 1 | A decoded group is presented |
| out_ready | input | 1 | Downstream accepts the group |
| out_slot_vld | output | NWAY | Per-slot valid after truncation |
| out_addr | output | NWAY*ADDR_W | Presented addresses |
| out_insn | output | NWAY*INSN_W | Presented instruction bits |
| out_opnd | output | NWAY*OPND_W | Presented operand fields |
| flush_o | output | 1 | One-cycle hard flush to front-end units |
| redirect_o | output | ADDR_W | Redirect target during flush |

## Verification
A group write and the queue clear can fall in the same cycle. The bench provokes this by offering a group exactly in the flush cycle that follows the acceptance of a cut group, and then requires `out_valid` to remain 0, so the write must have lost to the clear. The second coincidence is a last-slot branch waiting on its successor group while that successor arrives. The bench offers the second group while the first is deferred and judges the outcome by the mask that is then presented and by the presence or absence of a flush, with targets computed from the offset arithmetic.

// File: rtl/decode_pkg.sv
package decode_pkg;

    typedef enum logic {
        ST_RUN,
        ST_FLUSH
    } dec_state_e;

    typedef enum logic [1:0] {
        HD_EMPTY,
        HD_DEFER,
        HD_READY
    } head_cls_e;

    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] UBR_OPC = 6'b111000;
    localparam int OFF_W = 20;

endpackage

// File: rtl/group_queue.sv
module group_queue #(
    parameter int NWAY   = 4,
    parameter int QDEPTH = 32,
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int OPND_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [NWAY-1:0]                push_vld,
    input  logic [NWAY-1:0][ADDR_W-1:0]    push_addr,
    input  logic [NWAY-1:0][INSN_W-1:0]    push_insn,
    input  logic [NWAY-1:0][OPND_W-1:0]    push_opnd,
    input  logic                           pop,
    output logic [NWAY-1:0]                head_vld,
    output logic [NWAY-1:0][ADDR_W-1:0]    head_addr,
    output logic [NWAY-1:0][INSN_W-1:0]    head_insn,
    output logic [NWAY-1:0][OPND_W-1:0]    head_opnd,
    output logic [ADDR_W-1:0]              next_addr,
    output logic                           next_avail,
    output logic                           empty,
    output logic                           full
);

    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [NWAY-1:0]             m_vld  [QDEPTH];
    logic [NWAY-1:0][ADDR_W-1:0] m_addr [QDEPTH];
    logic [NWAY-1:0][INSN_W-1:0] m_insn [QDEPTH];
    logic [NWAY-1:0][OPND_W-1:0] m_opnd [QDEPTH];

    logic [PTR_W-1:0] wr_q, rd_q, rd_nx;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            m_vld[wr_q]  <= push_vld;
            m_addr[wr_q] <= push_addr;
            m_insn[wr_q] <= push_insn;
            m_opnd[wr_q] <= push_opnd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= ptr_inc(wr_q);
            if (pop)  rd_q <= ptr_inc(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rd_nx      = ptr_inc(rd_q);
    assign head_vld   = m_vld[rd_q];
    assign head_addr  = m_addr[rd_q];
    assign head_insn  = m_insn[rd_q];
    assign head_opnd  = m_opnd[rd_q];
    assign next_addr  = m_addr[rd_nx][0];
    assign next_avail = (cnt_q >= CNT_W'(2));
    assign empty      = (cnt_q == '0);
    assign full       = (cnt_q == CNT_W'(QDEPTH));

endmodule

// File: rtl/branch_scan.sv
module branch_scan
    import decode_pkg::*;
#(
    parameter int NWAY   = 4,
    parameter int ADDR_W = 32
) (
    input  logic [NWAY-1:0]              slot_vld,
    input  logic [NWAY-1:0][ADDR_W-1:0]  addr,
    input  logic [NWAY-1:0][OPC_W-1:0]   opc,
    input  logic [NWAY-1:0][OFF_W-1:0]   off,
    input  logic [ADDR_W-1:0]            next_addr,
    input  logic                         next_avail,
    output logic [NWAY-1:0]              keep,
    output logic                         mismatch,
    output logic                         defer,
    output logic [ADDR_W-1:0]            target
);

    logic [NWAY:0]             vld_ext;
    logic [NWAY:0][ADDR_W-1:0] addr_ext;

    assign vld_ext  = {1'b0, slot_vld};
    assign addr_ext = {next_addr, addr};

    always_comb begin
        logic              stop;
        logic              known;
        logic [ADDR_W-1:0] off_x;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] succ;
        keep     = '0;
        mismatch = 1'b0;
        defer    = 1'b0;
        target   = '0;
        stop     = 1'b0;
        known    = 1'b0;
        off_x    = '0;
        tgt      = '0;
        succ     = '0;
        for (int i = 0; i < NWAY; i++) begin
            if (!stop && slot_vld[i]) begin
                keep[i] = 1'b1;
                if (opc[i] == UBR_OPC) begin
                    off_x = {{(ADDR_W-OFF_W){off[i][OFF_W-1]}}, off[i]};
                    tgt   = addr[i] + (off_x << 2);
                    if (vld_ext[i+1]) begin
                        succ  = addr_ext[i+1];
                        known = 1'b1;
                    end else begin
                        succ  = next_addr;
                        known = next_avail;
                    end
                    if (!known) begin
                        defer = 1'b1;
                        stop  = 1'b1;
                    end else if (succ != tgt) begin
                        mismatch = 1'b1;
                        target   = tgt;
                        stop     = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/decode_redirect_stage.sv
module decode_redirect_stage
    import decode_pkg::*;
#(
    parameter int NWAY   = 4,
    parameter int QDEPTH = 32,
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int OPND_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [NWAY-1:0]                in_slot_vld,
    input  logic [NWAY-1:0][ADDR_W-1:0]    in_addr,
    input  logic [NWAY-1:0][INSN_W-1:0]    in_insn,
    input  logic [NWAY-1:0][OPND_W-1:0]    in_opnd,
    output logic                           q_full,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [NWAY-1:0]                out_slot_vld,
    output logic [NWAY-1:0][ADDR_W-1:0]    out_addr,
    output logic [NWAY-1:0][INSN_W-1:0]    out_insn,
    output logic [NWAY-1:0][OPND_W-1:0]    out_opnd,
    output logic                           flush_o,
    output logic [ADDR_W-1:0]              redirect_o
);

    dec_state_e state_q, state_d;
    head_cls_e  head_cls;

    logic              q_clr, q_push, q_pop, q_empty;
    logic [NWAY-1:0]   h_vld;
    logic [ADDR_W-1:0] nx_addr;
    logic              nx_avail;
    logic [NWAY-1:0]   keep;
    logic              mismatch, defer;
    logic [ADDR_W-1:0] tgt, redir_q;

    logic [NWAY-1:0][OPC_W-1:0] h_opc;
    logic [NWAY-1:0][OFF_W-1:0] h_off;

    assign q_clr  = (state_q == ST_FLUSH);
    assign q_push = in_valid && !q_full && (state_q == ST_RUN);
    assign q_pop  = out_valid && out_ready;

    group_queue #(
        .NWAY(NWAY), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W),
        .INSN_W(INSN_W), .OPND_W(OPND_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (q_clr),
        .push       (q_push),
        .push_vld   (in_slot_vld),
        .push_addr  (in_addr),
        .push_insn  (in_insn),
        .push_opnd  (in_opnd),
        .pop        (q_pop),
        .head_vld   (h_vld),
        .head_addr  (out_addr),
        .head_insn  (out_insn),
        .head_opnd  (out_opnd),
        .next_addr  (nx_addr),
        .next_avail (nx_avail),
        .empty      (q_empty),
        .full       (q_full)
    );

    for (genvar g = 0; g < NWAY; g++) begin : g_fields
        assign h_opc[g] = out_insn[g][INSN_W-1 -: OPC_W];
        assign h_off[g] = out_insn[g][OFF_W-1:0];
    end

    branch_scan #(.NWAY(NWAY), .ADDR_W(ADDR_W)) u_scan (
        .slot_vld   (h_vld),
        .addr       (out_addr),
        .opc        (h_opc),
        .off        (h_off),
        .next_addr  (nx_addr),
        .next_avail (nx_avail),
        .keep       (keep),
        .mismatch   (mismatch),
        .defer      (defer),
        .target     (tgt)
    );

    assign out_slot_vld = keep;

    always_comb begin
        if (q_empty)    head_cls = HD_EMPTY;
        else if (defer) head_cls = HD_DEFER;
        else            head_cls = HD_READY;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 redir_q <= '0;
        else if (q_pop && mismatch) redir_q <= tgt;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        out_valid  = 1'b0;
        flush_o    = 1'b0;
        redirect_o = '0;
        unique case (state_q)
            ST_RUN: begin
                out_valid = (head_cls == HD_READY);
                if (out_valid && out_ready && mismatch) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                flush_o    = 1'b1;
                redirect_o = redir_q;
                state_d    = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

endmodule

// File: rtl/decode_redirect_stage_chk.sv
module decode_redirect_stage_chk #(
    parameter int NWAY   = 4,
    parameter int ADDR_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          q_full,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic [NWAY-1:0]               out_slot_vld,
    input logic [NWAY-1:0][ADDR_W-1:0]   out_addr,
    input logic                          flush_o,
    input logic [ADDR_W-1:0]             redirect_o
);

    a_r4_hold_group: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_slot_vld)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    a_r7_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> $past(out_valid && out_ready));

    a_r7_redirect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o |-> (redirect_o == '0));

    a_r10_drained: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !out_valid ##1 !out_valid);

    a_r3_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !(out_valid && out_ready)) |=> q_full);

endmodule

bind decode_redirect_stage decode_redirect_stage_chk #(
    .NWAY(NWAY), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/decode_redirect_stage_tb_top.sv
module decode_redirect_stage_tb_top;

    localparam int NW = 4;
    localparam int QD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NW-1:0] in_slot_vld = '0;
    logic [NW-1:0][31:0] in_addr = '0;
    logic [NW-1:0][31:0] in_insn = '0;
    logic [NW-1:0][7:0]  in_opnd = '0;
    logic q_full, out_valid, flush_o;
    logic out_ready = 1'b0;
    logic [NW-1:0] out_slot_vld;
    logic [NW-1:0][31:0] out_addr, out_insn;
    logic [NW-1:0][7:0]  out_opnd;
    logic [31:0] redirect_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NW-1:0][31:0] g_a, g_i;
    int offs [3] = '{-3, 2, 7};

    always #10 clk = ~clk; // 20 ns period, 50 MHz

    decode_redirect_stage #(
        .NWAY(NW), .QDEPTH(QD), .ADDR_W(32), .INSN_W(32), .OPND_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot_vld(in_slot_vld),
        .in_addr(in_addr), .in_insn(in_insn), .in_opnd(in_opnd), .q_full(q_full),
        .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
        .out_addr(out_addr), .out_insn(out_insn), .out_opnd(out_opnd),
        .flush_o(flush_o), .redirect_o(redirect_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] br(input int off);
        logic [31:0] o = off;
        return {6'b111000, 6'b000000, o[19:0]};
    endfunction

    function automatic logic [31:0] tgt(input logic [31:0] a, input int off);
        return a + 32'(off * 4);
    endfunction

    task automatic fill_seq(input logic [31:0] base);
        for (int j = 0; j < NW; j++) begin
            g_a[j] = base + 32'(4 * j);
            g_i[j] = 32'h0001_0000 + 32'(j);
        end
    endtask

    task automatic drive(input logic [NW-1:0] v);
        in_slot_vld = v;
        in_addr = g_a;
        in_insn = g_i;
        for (int j = 0; j < NW; j++) in_opnd[j] = g_a[j][7:0] ^ 8'h5a;
        in_valid = 1'b1;
    endtask

    task automatic push_grp(input logic [NW-1:0] v);
        drive(v);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic [NW-1:0] emask, input logic [31:0] ea0,
                           input bit eflush, input logic [31:0] et, input string tag);
        chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 1);
        chk(out_slot_vld == emask, {tag, " mask"}, 64'(out_slot_vld), 64'(emask));
        chk(out_addr[0] == ea0, {tag, " addr0"}, 64'(out_addr[0]), 64'(ea0));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(flush_o == eflush, {tag, " flush"}, 64'(flush_o), 64'(eflush));
        if (eflush) begin
            chk(redirect_o == et, {tag, " redirect"}, 64'(redirect_o), 64'(et));
            @(negedge clk);
            chk(flush_o == 1'b0 && out_valid == 1'b0, {tag, " R10 after flush"},
                64'({flush_o, out_valid}), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0 && flush_o == 0 && q_full == 0, "R1 flags",
            64'({out_valid, flush_o, q_full}), 0);
        chk(redirect_o == 0, "R1 redirect", 64'(redirect_o), 0);

        // R2 / R3 / R4: fill, overflow attempt, backpressure, drain
        for (int n = 0; n < QD; n++) begin
            fill_seq(32'h100 * (n + 1));
            push_grp(4'((1 << (n + 1)) - 1));
        end
        chk(q_full == 1, "R3 full", 64'(q_full), 1);
        fill_seq(32'h900);
        push_grp(4'hF);
        repeat (3) @(negedge clk);
        chk(out_valid == 1 && out_addr[0] == 32'h100, "R4 held", 64'(out_addr[0]), 64'h100);
        chk(out_insn[0] == 32'h0001_0000, "R2 insn", 64'(out_insn[0]), 64'h10000);
        chk(out_opnd[0] == (8'h00 ^ 8'h5a), "R2 opnd", 64'(out_opnd[0]), 64'h5a);
        for (int n = 0; n < QD; n++)
            pop_chk(4'((1 << (n + 1)) - 1), 32'h100 * (n + 1), 0, 0, "R2 order");
        chk(out_valid == 0, "R3 dropped write", 64'(out_valid), 0);

        // R5 / R6 / R7 sweep over branch slot, offset and agreement
        for (int k = 0; k < 3; k++) begin
            for (int oi = 0; oi < 3; oi++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [31:0] t;
                    fill_seq(32'h1000);
                    g_i[k] = br(offs[oi]);
                    t = tgt(g_a[k], offs[oi]);
                    for (int j = k + 1; j < NW; j++)
                        g_a[j] = t + 32'(m * 8) + 32'(4 * (j - k - 1));
                    push_grp(4'hF);
                    if (m == 0) pop_chk(4'hF, 32'h1000, 0, 0, "R6 agree");
                    else        pop_chk(4'((1 << (k + 1)) - 1), 32'h1000, 1, t, "R7 cut R5");
                end
            end
        end

        // R8 first disagreeing branch wins
        fill_seq(32'h2000);
        g_i[0] = br(5);
        g_i[2] = br(9);
        push_grp(4'hF);
        pop_chk(4'h1, 32'h2000, 1, 32'h2014, "R8 first");
        fill_seq(32'h2000);
        g_i[0] = br(5);
        g_a[1] = 32'h2014; g_a[2] = 32'h2018; g_a[3] = 32'h201c;
        g_i[2] = br(-2);
        push_grp(4'hF);
        pop_chk(4'h7, 32'h2000, 1, 32'h2010, "R8 later");

        // R9 last-slot branch, agreeing successor group
        fill_seq(32'h3000);
        g_i[3] = br(16);
        push_grp(4'hF);
        repeat (2) @(negedge clk);
        chk(out_valid == 0, "R9 deferred", 64'(out_valid), 0);
        fill_seq(32'h304c);
        push_grp(4'hF);
        pop_chk(4'hF, 32'h3000, 0, 0, "R9 agree");
        pop_chk(4'hF, 32'h304c, 0, 0, "R9 successor");

        // R9 last valid slot in a partial group, disagreeing successor
        fill_seq(32'h4000);
        g_i[1] = br(4);
        push_grp(4'h3);
        chk(out_valid == 0, "R9 partial deferred", 64'(out_valid), 0);
        fill_seq(32'h5000);
        push_grp(4'hF);
        pop_chk(4'h3, 32'h4000, 1, 32'h4014, "R9 disagree R10");

        // R10 write offered exactly in the flush cycle
        fill_seq(32'h6000);
        g_i[0] = br(-8);
        push_grp(4'hF);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(flush_o == 1, "R10 flush seen", 64'(flush_o), 1);
        fill_seq(32'h7000);
        push_grp(4'hF);
        chk(out_valid == 0, "R10 write in flush dropped", 64'(out_valid), 0);
        fill_seq(32'h7100);
        push_grp(4'hF);
        pop_chk(4'hF, 32'h7100, 0, 0, "R10 resume");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule